// File: doc/BRIEF.md
# Segment Limit and Access Checker

This block decides whether a single memory access may go ahead under the segment descriptor that a segment register holds in its hidden cache. Each request gives the byte offset, the access width, the kind of access (read, write or instruction fetch) and a flag for 64-bit operation, along with the cached descriptor fields. The block answers one cycle later with a general-protection flag and a not-present flag.

Outside 64-bit operation, the block scales the 20-bit raw limit by the granularity bit. It then builds the legal offset window. For an expand-up segment the window runs upward from zero. For an expand-down data segment it runs from just above the limit to a ceiling that the D/B bit selects. The block also checks that the requested kind of access is allowed for a code, data or system segment. In 64-bit operation all of those checks are skipped, and only the canonical form of the first and last byte address is tested. Upstream logic registers the selected descriptor fields. Downstream logic turns the flags into an exception.

Top module: `seg_access_chk`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `rsp_valid`, `gp_fault` and `np_fault` are all 0.
- R2: `rsp_valid` goes high exactly one cycle after `req_valid` is high. In the same cycle the fault flags give the verdict for that request. In a cycle with `req_valid` low, `rsp_valid` is 0 the next cycle and both fault flags keep their previous values.
- R3: The effective limit equals the raw limit when `desc_gran` is 0. When `desc_gran` is 1, it is the raw limit shifted left by 12 with the low 12 bits set to ones, so a raw limit of 0 allows offsets 0 through 4095.
- R4: Outside 64-bit operation only `acc_offset[31:0]` is used, and the bits above are ignored. For an expand-up segment, the access covers bytes offset through offset+`acc_size`-1 computed without wrapping. It is legal only if that last byte is at or below the effective limit and below 2^32.
- R5: A data segment (`desc_type[2]`=0) with `desc_type[1]`=1 expands down. The access is legal only if the offset is above the effective limit and the last byte is at or below the ceiling. The ceiling is 0xFFFF when `desc_big`=0 and 0xFFFFFFFF when `desc_big`=1.
- R6: For a data segment, a write raises `gp_fault` when `desc_type[0]` (writable) is 0, and an instruction fetch always raises `gp_fault`.
- R7: For a code segment (`desc_type[2]`=1), a write always raises `gp_fault`. A read raises `gp_fault` when `desc_type[0]` (readable) is 0, and a fetch is allowed. The limit check is always expand-up, and `desc_type[1]` has no effect on the range.
- R8: Outside 64-bit operation, a present descriptor with `desc_user`=0 (system segment) raises `gp_fault` for every access kind.
- R9: Outside 64-bit operation, a descriptor with `desc_present`=0 sets `np_fault` to 1 and `gp_fault` to 0, whatever the other fields are.
- R10: With `long_mode`=1, limit, rights, present and system checks are all skipped, and `np_fault` is 0. `gp_fault` is 1 exactly when the first byte address or the last byte address (offset+size-1, wrapping mod 2^64) is non-canonical, meaning bits 63:47 are not all equal.
- R11: `acc_kind` is encoded as 0 for read, 1 for write and 2 for fetch. Code 3 is checked exactly like a read. `acc_size` carries the byte count 1 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| acc_offset | input | 64 | Byte offset of the access (full address in 64-bit operation) |
| acc_size | input | 4 | Access width in bytes, 1 to 8 |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| long_mode | input | 1 | 64-bit operation: canonical check only |
| desc_limit | input | 20 | Raw segment limit from the cached descriptor |
| desc_gran | input | 1 | Granularity: limit counts 4 KB blocks |
| desc_big | input | 1 | D/B bit: selects the expand-down ceiling |
| desc_type | input | 3 | [2] code, [1] expand-down or conforming, [0] writable or readable |
| desc_user | input | 1 | 1 for code or data segment, 0 for system segment |
| desc_present | input | 1 | Segment present |
| rsp_valid | output | 1 | Verdict for the previous cycle's request |
| gp_fault | output | 1 | General-protection violation |
| np_fault | output | 1 | Segment-not-present |

## Verification
The properties assume `acc_size` always lies between 1 and 8. The check that a zero-extended 32-bit offset stays canonical in 64-bit operation relies on that bound, since the last byte then cannot reach bit 47. The rights properties also assume the descriptor fields are stable during the cycle the request is sampled. The stimulus draws sizes only from 1 to 8 and holds every input steady from one falling edge to the next. Random vectors in 64-bit operation build offsets near both canonical edges rather than from arbitrary 64-bit values, so that boundary crossings really occur.

// File: rtl/sac_pkg.sv
package sac_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  // positions inside the three type bits carried on the port
  localparam int unsigned TY_CODE = 2;
  localparam int unsigned TY_DIR  = 1;
  localparam int unsigned TY_PERM = 0;

endpackage

// File: rtl/sac_limit_expand.sv
module sac_limit_expand #(
  parameter int unsigned LIM_W      = 20,
  parameter int unsigned GRAN_SHIFT = 12,
  parameter int unsigned LEG_W      = 32
) (
  input  logic [LIM_W-1:0] raw_limit,
  input  logic             gran,
  output logic [LEG_W-1:0] eff_limit
);
  localparam int unsigned SCALED_W = LIM_W + GRAN_SHIFT;

  logic [SCALED_W-1:0] scaled;

  always_comb begin
    if (gran) scaled = {raw_limit, {GRAN_SHIFT{1'b1}}};
    else      scaled = SCALED_W'(raw_limit);
    eff_limit = LEG_W'(scaled);
  end
endmodule

// File: rtl/sac_range_chk.sv
module sac_range_chk #(
  parameter int unsigned LEG_W   = 32,
  parameter int unsigned SMALL_W = 16,
  parameter int unsigned SIZE_W  = 4
) (
  input  logic [LEG_W-1:0]  offset_lo,
  input  logic [SIZE_W-1:0] size,
  input  logic [LEG_W-1:0]  eff_limit,
  input  logic              expand_down,
  input  logic              big,
  output logic              in_range
);
  localparam int unsigned EXT_W = LEG_W + 1;

  logic [EXT_W-1:0] last_byte;
  logic [LEG_W-1:0] ceiling;

  always_comb begin
    last_byte = {1'b0, offset_lo} + EXT_W'(size) - EXT_W'(1);
    ceiling   = big ? {LEG_W{1'b1}} : LEG_W'({SMALL_W{1'b1}});
    if (expand_down)
      in_range = (offset_lo > eff_limit) && (last_byte <= {1'b0, ceiling});
    else
      in_range = (last_byte <= {1'b0, eff_limit});
  end
endmodule

// File: rtl/sac_rights_chk.sv
module sac_rights_chk
  import sac_pkg::*;
(
  input  logic [1:0] kind,
  input  logic       user_seg,
  input  logic [2:0] seg_type,
  output logic       rights_ok
);
  logic is_write, is_fetch, is_read;

  always_comb begin
    is_write = (kind == ACC_WRITE);
    is_fetch = (kind == ACC_FETCH);
    is_read  = (kind == ACC_READ) || (kind == ACC_RSVD);
    if (!user_seg)
      rights_ok = 1'b0;
    else if (seg_type[TY_CODE])
      rights_ok = !is_write && !(is_read && !seg_type[TY_PERM]);
    else
      rights_ok = !is_fetch && !(is_write && !seg_type[TY_PERM]);
  end
endmodule

// File: rtl/sac_canon_chk.sv
module sac_canon_chk #(
  parameter int unsigned OFS_W   = 64,
  parameter int unsigned VA_BITS = 48,
  parameter int unsigned SIZE_W  = 4
) (
  input  logic [OFS_W-1:0]  addr,
  input  logic [SIZE_W-1:0] size,
  output logic              canon_ok
);
  localparam int unsigned TOP_W = OFS_W - VA_BITS + 1;

  logic [OFS_W-1:0] last_addr;
  logic [TOP_W-1:0] first_top, last_top;
  logic             first_ok, last_ok;

  always_comb begin
    last_addr = addr + OFS_W'(size) - OFS_W'(1);
    first_top = addr[OFS_W-1:VA_BITS-1];
    last_top  = last_addr[OFS_W-1:VA_BITS-1];
    first_ok  = (&first_top) || !(|first_top);
    last_ok   = (&last_top) || !(|last_top);
    canon_ok  = first_ok && last_ok;
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import sac_pkg::*;
#(
  parameter int unsigned OFS_W      = 64,
  parameter int unsigned LIM_W      = 20,
  parameter int unsigned GRAN_SHIFT = 12,
  parameter int unsigned LEG_W      = 32,
  parameter int unsigned SMALL_W    = 16,
  parameter int unsigned VA_BITS    = 48,
  parameter int unsigned SIZE_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [OFS_W-1:0]  acc_offset,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic [1:0]        acc_kind,
  input  logic              long_mode,
  input  logic [LIM_W-1:0]  desc_limit,
  input  logic              desc_gran,
  input  logic              desc_big,
  input  logic [2:0]        desc_type,
  input  logic              desc_user,
  input  logic              desc_present,
  output logic              rsp_valid,
  output logic              gp_fault,
  output logic              np_fault
);
  logic [LEG_W-1:0] eff_limit;
  logic             in_range, rights_ok, canon_ok, expand_down;
  logic             gp_nxt, np_nxt;
  logic             valid_q, gp_q, np_q;

  sac_limit_expand #(.LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT), .LEG_W(LEG_W)) u_lim (
    .raw_limit (desc_limit),
    .gran      (desc_gran),
    .eff_limit (eff_limit)
  );

  assign expand_down = !desc_type[TY_CODE] && desc_type[TY_DIR];

  sac_range_chk #(.LEG_W(LEG_W), .SMALL_W(SMALL_W), .SIZE_W(SIZE_W)) u_rng (
    .offset_lo   (acc_offset[LEG_W-1:0]),
    .size        (acc_size),
    .eff_limit   (eff_limit),
    .expand_down (expand_down),
    .big         (desc_big),
    .in_range    (in_range)
  );

  sac_rights_chk u_rgt (
    .kind      (acc_kind),
    .user_seg  (desc_user),
    .seg_type  (desc_type),
    .rights_ok (rights_ok)
  );

  sac_canon_chk #(.OFS_W(OFS_W), .VA_BITS(VA_BITS), .SIZE_W(SIZE_W)) u_can (
    .addr     (acc_offset),
    .size     (acc_size),
    .canon_ok (canon_ok)
  );

  // verdict for the request presented this cycle
  always_comb begin
    if (long_mode) begin
      gp_nxt = !canon_ok;
      np_nxt = 1'b0;
    end else if (!desc_present) begin
      gp_nxt = 1'b0;
      np_nxt = 1'b1;
    end else begin
      gp_nxt = !rights_ok || !in_range;
      np_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      gp_q    <= 1'b0;
      np_q    <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        gp_q <= gp_nxt;
        np_q <= np_nxt;
      end
    end
  end

  assign rsp_valid = valid_q;
  assign gp_fault  = gp_q;
  assign np_fault  = np_q;
endmodule

// File: rtl/sac_checker.sv
module sac_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] ofs_hi,
  input logic [1:0]  acc_kind,
  input logic        long_mode,
  input logic [2:0]  desc_type,
  input logic        desc_user,
  input logic        desc_present,
  input logic        rsp_valid,
  input logic        gp_fault,
  input logic        np_fault
);
  logic legacy_req;
  assign legacy_req = req_valid && !long_mode && desc_present && desc_user;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  a_r2_hold_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(gp_fault) && $stable(np_fault)));

  a_r9_not_present: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !long_mode && !desc_present) |=> (np_fault && !gp_fault));

  a_r8_system_seg: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !long_mode && desc_present && !desc_user) |=> gp_fault);

  a_r7_code_write: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_req && desc_type[2] && acc_kind == 2'd1) |=> gp_fault);

  a_r6_data_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy_req && !desc_type[2] && acc_kind == 2'd2) |=> gp_fault);

  a_r10_long_no_np: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && long_mode) |=> !np_fault);

  a_r10_low_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && long_mode && ofs_hi == 32'd0) |=> !gp_fault);

  a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(gp_fault && np_fault));
endmodule

bind seg_access_chk sac_checker u_sac_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .ofs_hi       (acc_offset[63:32]),
  .acc_kind     (acc_kind),
  .long_mode    (long_mode),
  .desc_type    (desc_type),
  .desc_user    (desc_user),
  .desc_present (desc_present),
  .rsp_valid    (rsp_valid),
  .gp_fault     (gp_fault),
  .np_fault     (np_fault)
);

// File: tb/seg_access_chk_bench.sv
module seg_access_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] acc_offset;
  logic [3:0]  acc_size;
  logic [1:0]  acc_kind;
  logic        long_mode;
  logic [19:0] desc_limit;
  logic        desc_gran, desc_big;
  logic [2:0]  desc_type;
  logic        desc_user, desc_present;
  logic        rsp_valid, gp_fault, np_fault;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    bit    valid;
    bit    gp;
    bit    np;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  bit   held_gp = 0;
  bit   held_np = 0;

  always #5 clk = ~clk;

  seg_access_chk u_seg_access_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_offset(acc_offset),
    .acc_size(acc_size), .acc_kind(acc_kind), .long_mode(long_mode),
    .desc_limit(desc_limit), .desc_gran(desc_gran), .desc_big(desc_big),
    .desc_type(desc_type), .desc_user(desc_user), .desc_present(desc_present),
    .rsp_valid(rsp_valid), .gp_fault(gp_fault), .np_fault(np_fault)
  );

  function automatic bit canon(input logic [63:0] a);
    return (a[63:47] == 17'h0) || (a[63:47] == 17'h1FFFF);
  endfunction

  function automatic void ref_model(
    input logic [63:0] off, input int sz, input int kind, input bit lm,
    input int unsigned lim, input bit g, input bit b, input bit [2:0] typ,
    input bit s, input bit p, output bit gp, output bit np);
    logic [63:0] last64;
    longint unsigned lo, last, elim, up;
    bit bad, ok;
    gp = 0; np = 0;
    if (lm) begin
      last64 = off + 64'(sz) - 64'd1;
      gp = !(canon(off) && canon(last64));
    end else if (!p) begin
      np = 1;
    end else begin
      elim = g ? ((longint'(lim) << 12) | 64'hFFF) : longint'(lim);
      lo   = longint'(off[31:0]);
      last = lo + longint'(sz) - 1;
      if (!s)          bad = 1;
      else if (typ[2]) bad = (kind == 1) || ((kind == 0 || kind == 3) && !typ[0]);
      else             bad = (kind == 2) || (kind == 1 && !typ[0]);
      if (!typ[2] && typ[1]) begin
        up = b ? 64'hFFFF_FFFF : 64'hFFFF;
        ok = (lo > elim) && (last <= up);
      end else begin
        ok = (last <= elim);
      end
      gp = bad || !ok;
    end
  endfunction

  task automatic compare();
    exp_t e;
    if (exp_q.size() == 0) return;
    e = exp_q.pop_front();
    checks++;
    if (rsp_valid !== e.valid || gp_fault !== e.gp || np_fault !== e.np) begin
      errors++;
      $display("FAIL %s: got valid=%0b gp=%0b np=%0b expected valid=%0b gp=%0b np=%0b",
               e.tag, rsp_valid, gp_fault, np_fault, e.valid, e.gp, e.np);
    end
  endtask

  task automatic apply(input bit v, input logic [63:0] off, input int sz, input int kind,
                       input bit lm, input int unsigned lim, input bit g, input bit b,
                       input bit [2:0] typ, input bit s, input bit p, input string tag);
    exp_t e;
    bit gp, np;
    @(negedge clk);
    compare();
    req_valid = v; acc_offset = off; acc_size = 4'(sz); acc_kind = 2'(kind);
    long_mode = lm; desc_limit = 20'(lim); desc_gran = g; desc_big = b;
    desc_type = typ; desc_user = s; desc_present = p;
    ref_model(off, sz, kind, lm, lim, g, b, typ, s, p, gp, np);
    if (v) begin held_gp = gp; held_np = np; end
    e.valid = v; e.gp = held_gp; e.np = held_np; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string tag);
    apply(0, 64'h0, 1, 0, 0, 0, 0, 0, 3'b001, 1, 1, tag);
  endtask

  // data read/write expand-up access, legacy operation
  task automatic dru(input logic [63:0] off, input int sz, input int unsigned lim,
                     input bit g, input string tag);
    apply(1, off, sz, 0, 0, lim, g, 0, 3'b001, 1, 1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 1; acc_offset = '1; acc_size = 4'd1; acc_kind = 2'd1;
    long_mode = 0; desc_limit = '0; desc_gran = 0; desc_big = 0;
    desc_type = 3'b100; desc_user = 1; desc_present = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || gp_fault !== 0 || np_fault !== 0) begin
      errors++;
      $display("FAIL R1: got valid=%0b gp=%0b np=%0b expected 0 0 0", rsp_valid, gp_fault, np_fault);
    end
    req_valid = 0;
    rst_n = 1;
    idle("R1");

    // R4 expand-up byte limit
    dru(64'hFC, 4, 'h100, 0, "R4");
    dru(64'hFD, 4, 'h100, 0, "R4");
    dru(64'h100, 1, 'h100, 0, "R4");
    dru(64'h101, 1, 'h100, 0, "R4");
    dru(64'hDEAD_0000_0000_0010, 1, 'h100, 0, "R4");
    dru(64'hFFFF_FFFE, 2, 'hFFFFF, 1, "R4");
    dru(64'hFFFF_FFFE, 4, 'hFFFFF, 1, "R4");
    // R3 granularity
    dru(64'hFFF, 1, 0, 1, "R3");
    dru(64'hFFC, 4, 0, 1, "R3");
    dru(64'h1000, 1, 0, 1, "R3");
    dru(64'h0, 1, 0, 0, "R3");
    dru(64'h1, 1, 0, 0, "R3");
    dru(64'h2FFF, 1, 2, 1, "R3");
    dru(64'h3000, 1, 2, 1, "R3");
    // R5 expand-down
    apply(1, 64'h0FFF, 1, 0, 0, 'hFFF, 0, 0, 3'b011, 1, 1, "R5");
    apply(1, 64'h1000, 1, 0, 0, 'hFFF, 0, 0, 3'b011, 1, 1, "R5");
    apply(1, 64'hFFFE, 2, 1, 0, 'hFFF, 0, 0, 3'b011, 1, 1, "R5");
    apply(1, 64'hFFFF, 2, 1, 0, 'hFFF, 0, 0, 3'b011, 1, 1, "R5");
    apply(1, 64'hFFFF, 2, 1, 0, 'hFFF, 0, 1, 3'b011, 1, 1, "R5");
    apply(1, 64'hFFFF_FFFC, 4, 0, 0, 'hFFF, 0, 1, 3'b011, 1, 1, "R5");
    apply(1, 64'hFFFF_FFFD, 4, 0, 0, 'hFFF, 0, 1, 3'b011, 1, 1, "R5");
    // R6 data rights, R11 reserved kind
    apply(1, 64'h10, 1, 1, 0, 'h100, 0, 0, 3'b000, 1, 1, "R6");
    apply(1, 64'h10, 1, 0, 0, 'h100, 0, 0, 3'b000, 1, 1, "R6");
    apply(1, 64'h10, 1, 2, 0, 'h100, 0, 0, 3'b001, 1, 1, "R6");
    apply(1, 64'h10, 1, 3, 0, 'h100, 0, 0, 3'b000, 1, 1, "R11");
    // R7 code rights and range
    apply(1, 64'h10, 1, 0, 0, 'h100, 0, 0, 3'b100, 1, 1, "R7");
    apply(1, 64'h10, 1, 2, 0, 'h100, 0, 0, 3'b100, 1, 1, "R7");
    apply(1, 64'h10, 1, 1, 0, 'h100, 0, 0, 3'b101, 1, 1, "R7");
    apply(1, 64'h10, 1, 0, 0, 'h100, 0, 0, 3'b101, 1, 1, "R7");
    apply(1, 64'h20, 1, 2, 0, 'h10, 0, 0, 3'b110, 1, 1, "R7");
    apply(1, 64'h8, 1, 2, 0, 'h10, 0, 0, 3'b110, 1, 1, "R7");
    apply(1, 64'h10, 1, 3, 0, 'h100, 0, 0, 3'b100, 1, 1, "R11");
    // R8 system segment
    apply(1, 64'h10, 1, 0, 0, 'h100, 0, 0, 3'b001, 0, 1, "R8");
    apply(1, 64'h10, 1, 2, 0, 'h100, 0, 0, 3'b101, 0, 1, "R8");
    // R9 not present
    apply(1, 64'h10, 1, 0, 0, 'h100, 0, 0, 3'b001, 1, 0, "R9");
    apply(1, 64'hFFFF, 8, 1, 0, 0, 0, 0, 3'b100, 0, 0, "R9");
    // R2 hold over idle cycles
    idle("R2");
    idle("R2");
    dru(64'h200, 1, 'h100, 0, "R2");
    idle("R2");
    idle("R2");
    // R10 64-bit operation
    apply(1, 64'h0000_7FFF_FFFF_FFF8, 8, 1, 1, 0, 0, 0, 3'b000, 0, 0, "R10");
    apply(1, 64'h0000_7FFF_FFFF_FFFC, 8, 1, 1, 0, 0, 0, 3'b000, 0, 0, "R10");
    apply(1, 64'hFFFF_8000_0000_0000, 1, 0, 1, 0, 0, 0, 3'b000, 1, 1, "R10");
    apply(1, 64'hFFFF_7FFF_FFFF_FFFF, 1, 0, 1, 0, 0, 0, 3'b000, 1, 1, "R10");
    apply(1, 64'h0001_0000_0000_0000, 1, 2, 1, 0, 0, 0, 3'b001, 1, 1, "R10");
    apply(1, 64'hFFFF_FFFF_FFFF_FFFC, 8, 0, 1, 0, 0, 0, 3'b001, 1, 1, "R10");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [63:0] off;
      bit lm, p, top;
      string tag;
      lm  = ($urandom_range(0, 3) == 0);
      p   = ($urandom_range(0, 7) != 0);
      top = $urandom_range(0, 1);
      if (lm)
        off = {{16{top}}, 1'b1 ^ ($urandom_range(0, 3) == 0 ? top : ~top),
               31'h7FFF_FFFF - 31'($urandom_range(0, 15)), 16'($urandom)};
      else
        off = {32'($urandom), 32'($urandom)};
      if (!lm && $urandom_range(0, 1)) off[31:16] = '0;
      tag = lm ? "R10" : (!p ? "R9" : "R4");
      apply($urandom_range(0, 5) != 0, off, $urandom_range(1, 8), $urandom_range(0, 3), lm,
            $urandom_range(0, 20'hFFFFF), $urandom_range(0, 1), $urandom_range(0, 1),
            3'($urandom_range(0, 7)), $urandom_range(0, 4) != 0, p, tag);
    end
    idle("R2");
    idle("R2");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule